// File: doc/BRIEF.md
# Status-Conditioned Interrupt/Branch/Wait Evaluator

This block decides, for one DMA command at a time, whether the channel should stall, raise an interrupt, and branch. Each command carries three 2-bit condition fields (interrupt, branch, wait). Each field is judged against four device-status bits. The judgement goes through its own select register, which holds a mask and a compare value. The command sequencer pulses `eval_strobe` with the command's fields, the current status and the pointers. One cycle later the block returns its verdict and the command pointer the channel should use next.

The wait decision dominates. A stalled pass suppresses status write-back, the interrupt and the branch, and leaves the pointer and the branch-taken flag untouched, so the same command is evaluated again later. A pass that is not stalled does two things. It signals write-back and, in the same cycle, reports whether the interrupt fires. It then either loads the command-dependent pointer and sets the branch-taken flag, or steps the pointer by one descriptor (16) and clears the flag.

Top module: `cond_eval_top`

## Requirements
- R1: After reset, result_valid, irq_req, stall, writeback and branch_taken are 0, bt_flag is 0 and next_ptr is 0.
- R2: The condition for a purpose is true when (dev_status AND sel[19:16]) equals (sel[3:0] AND sel[19:16]). All other bits of the select register have no effect. A mask of zero makes the condition always true.
- R3: A 2-bit condition field acts as follows: 2'b00 never, 2'b01 when the condition is true, 2'b10 when the condition is false, 2'b11 always.
- R4: result_valid is 1 exactly in the cycle after a cycle with eval_strobe high. irq_req, stall, writeback and branch_taken are 0 whenever result_valid is 0.
- R5: When the wait field acts, stall is 1, and irq_req, writeback and branch_taken are 0. next_ptr and bt_flag keep their previous values.
- R6: When not stalled, writeback is 1, and irq_req is 1 exactly when the interrupt field acts.
- R7: When not stalled and the branch field acts, branch_taken is 1, next_ptr equals dep_ptr and bt_flag becomes 1.
- R8: When not stalled and the branch field does not act, branch_taken is 0, next_ptr equals cur_ptr + 16 (modulo 2^AW) and bt_flag becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_strobe | input | 1 | Evaluate the presented command this cycle |
| intr_mode | input | 2 | Interrupt condition field |
| branch_mode | input | 2 | Branch condition field |
| wait_mode | input | 2 | Wait condition field |
| dev_status | input | 4 | Device-status bits of the channel |
| intr_select | input | 32 | Interrupt select register (mask 19:16, value 3:0) |
| branch_select | input | 32 | Branch select register (mask 19:16, value 3:0) |
| wait_select | input | 32 | Wait select register (mask 19:16, value 3:0) |
| cur_ptr | input | 32 | Current command pointer |
| dep_ptr | input | 32 | Command-dependent word (branch target) |
| result_valid | output | 1 | Verdict valid this cycle |
| stall | output | 1 | Wait asserted; pass skipped |
| writeback | output | 1 | Status write-back for this pass |
| irq_req | output | 1 | Interrupt request pulse |
| branch_taken | output | 1 | Branch taken this pass |
| next_ptr | output | 32 | Command pointer to use next |
| bt_flag | output | 1 | Branch-taken status flag |

## Verification
The hardest case to reach is a stall that arrives after a taken branch. Here the pointer and flag must be held rather than recomputed, and an interrupt field that would fire must be suppressed. Random select registers rarely produce this case together with a matching wait condition. The stimulus therefore mixes random passes with directed sequences: a taken branch, then a pass with wait forced to always and interrupt forced to always, with different pointers presented. The random passes also fill the unused select bits with noise. Directed cases cover a zero mask and pointer wrap at the top of the address space.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  typedef enum logic [1:0] {
    COND_NEVER    = 2'b00,
    COND_IF_TRUE  = 2'b01,
    COND_IF_FALSE = 2'b10,
    COND_ALWAYS   = 2'b11
  } cond_mode_e;

  localparam int NUM_PURPOSE = 3;
  localparam int PURP_INTR   = 0;
  localparam int PURP_BRANCH = 1;
  localparam int PURP_WAIT   = 2;

  function automatic logic mode_acts(cond_mode_e m, logic hit);
    case (m)
      COND_NEVER:    return 1'b0;
      COND_IF_TRUE:  return hit;
      COND_IF_FALSE: return !hit;
      default:       return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/cond_match.sv
module cond_match #(
  parameter int SEL_W    = 32,
  parameter int STAT_W   = 4,
  parameter int MASK_LSB = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [STAT_W-1:0] status,
  output logic              hit
);
  logic [STAT_W-1:0] mask_f;
  logic [STAT_W-1:0] value_f;
  logic              sel_unused_bits;

  assign mask_f  = sel[MASK_LSB +: STAT_W];
  assign value_f = sel[0 +: STAT_W];
  assign hit     = ((status & mask_f) == (value_f & mask_f));
  assign sel_unused_bits = ^sel;
endmodule

// File: rtl/cond_decide.sv
module cond_decide
  import cond_eval_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       hit,
  output logic       act
);
  cond_mode_e mode_e;
  assign mode_e = cond_mode_e'(mode);
  assign act    = mode_acts(mode_e, hit);
endmodule

// File: rtl/ptr_step.sv
module ptr_step #(
  parameter int AW     = 32,
  parameter int STRIDE = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] dep,
  input  logic          take,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);
  assign nxt = take ? dep : (cur + STEP);
endmodule

// File: rtl/cond_eval_top.sv
module cond_eval_top
  import cond_eval_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SEL_W    = 32,
  parameter int STAT_W   = 4,
  parameter int MASK_LSB = 16,
  parameter int STRIDE   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval_strobe,
  input  logic [1:0]        intr_mode,
  input  logic [1:0]        branch_mode,
  input  logic [1:0]        wait_mode,
  input  logic [STAT_W-1:0] dev_status,
  input  logic [SEL_W-1:0]  intr_select,
  input  logic [SEL_W-1:0]  branch_select,
  input  logic [SEL_W-1:0]  wait_select,
  input  logic [AW-1:0]     cur_ptr,
  input  logic [AW-1:0]     dep_ptr,
  output logic              result_valid,
  output logic              stall,
  output logic              writeback,
  output logic              irq_req,
  output logic              branch_taken,
  output logic [AW-1:0]     next_ptr,
  output logic              bt_flag
);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);

  logic [SEL_W-1:0] sel_arr  [NUM_PURPOSE];
  logic [1:0]       mode_arr [NUM_PURPOSE];
  logic [NUM_PURPOSE-1:0] hit_v;
  logic [NUM_PURPOSE-1:0] act_v;
  logic [AW-1:0]    step_ptr;

  assign sel_arr[PURP_INTR]    = intr_select;
  assign sel_arr[PURP_BRANCH]  = branch_select;
  assign sel_arr[PURP_WAIT]    = wait_select;
  assign mode_arr[PURP_INTR]   = intr_mode;
  assign mode_arr[PURP_BRANCH] = branch_mode;
  assign mode_arr[PURP_WAIT]   = wait_mode;

  for (genvar p = 0; p < NUM_PURPOSE; p++) begin : g_purpose
    cond_match #(.SEL_W(SEL_W), .STAT_W(STAT_W), .MASK_LSB(MASK_LSB)) u_match (
      .sel    (sel_arr[p]),
      .status (dev_status),
      .hit    (hit_v[p])
    );
    cond_decide u_decide (
      .mode (mode_arr[p]),
      .hit  (hit_v[p]),
      .act  (act_v[p])
    );
  end

  ptr_step #(.AW(AW), .STRIDE(STRIDE)) u_step (
    .cur  (cur_ptr),
    .dep  (dep_ptr),
    .take (act_v[PURP_BRANCH]),
    .nxt  (step_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_valid <= 1'b0;
      stall        <= 1'b0;
      writeback    <= 1'b0;
      irq_req      <= 1'b0;
      branch_taken <= 1'b0;
      next_ptr     <= '0;
      bt_flag      <= 1'b0;
    end else begin
      result_valid <= eval_strobe;
      stall        <= 1'b0;
      writeback    <= 1'b0;
      irq_req      <= 1'b0;
      branch_taken <= 1'b0;
      if (eval_strobe) begin
        stall <= act_v[PURP_WAIT];
        if (!act_v[PURP_WAIT]) begin
          writeback    <= 1'b1;
          irq_req      <= act_v[PURP_INTR];
          branch_taken <= act_v[PURP_BRANCH];
          next_ptr     <= step_ptr;
          bt_flag      <= act_v[PURP_BRANCH];
        end
      end
    end
  end

  // R4: verdict appears one cycle after the strobe
  a_r4_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    eval_strobe |=> result_valid);
  // R4: pulses only alongside a valid verdict
  a_r4_pulses_gated: assert property (@(posedge clk) disable iff (rst)
    (irq_req || stall || writeback || branch_taken) |-> result_valid);
  // R5: a stall suppresses the rest of the pass
  a_r5_stall_suppresses: assert property (@(posedge clk) disable iff (rst)
    stall |-> (!irq_req && !writeback && !branch_taken));
  // R5: pointer and flag hold through a stall
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (rst)
    stall |-> ($stable(next_ptr) && $stable(bt_flag)));
  // R6: every non-stalled pass writes status back
  a_r6_writeback: assert property (@(posedge clk) disable iff (rst)
    (result_valid && !stall) |-> writeback);
  // R7: taken branch sets the flag
  a_r7_taken_flag: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> bt_flag);
  // R8: sequential step advances by one descriptor
  a_r8_seq_step: assert property (@(posedge clk) disable iff (rst)
    (result_valid && !stall && !branch_taken) |->
      (next_ptr == $past(cur_ptr) + STEP && !bt_flag));

endmodule

// File: tb/cond_eval_top_bench.sv
module cond_eval_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        eval_strobe = 1'b0;
  logic [1:0]  intr_mode = '0, branch_mode = '0, wait_mode = '0;
  logic [3:0]  dev_status = '0;
  logic [31:0] intr_select = '0, branch_select = '0, wait_select = '0;
  logic [31:0] cur_ptr = '0, dep_ptr = '0;
  logic        result_valid, stall, writeback, irq_req, branch_taken, bt_flag;
  logic [31:0] next_ptr;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_ptr = '0;
  logic        exp_bt  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_eval_top u_cond_eval_top (
    .clk(clk), .rst(rst), .eval_strobe(eval_strobe),
    .intr_mode(intr_mode), .branch_mode(branch_mode), .wait_mode(wait_mode),
    .dev_status(dev_status), .intr_select(intr_select),
    .branch_select(branch_select), .wait_select(wait_select),
    .cur_ptr(cur_ptr), .dep_ptr(dep_ptr),
    .result_valid(result_valid), .stall(stall), .writeback(writeback),
    .irq_req(irq_req), .branch_taken(branch_taken),
    .next_ptr(next_ptr), .bt_flag(bt_flag)
  );

  function automatic logic cond_true(logic [31:0] sel, logic [3:0] st);
    logic [3:0] m = sel[19:16];
    return (st & m) == (sel[3:0] & m);
  endfunction

  function automatic logic acts(logic [1:0] md, logic c);
    case (md)
      2'b00: return 1'b0;
      2'b01: return c;
      2'b10: return !c;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic evaluate(logic [1:0] im, logic [1:0] bm, logic [1:0] wm,
                          logic [3:0] st, logic [31:0] is, logic [31:0] bs,
                          logic [31:0] ws, logic [31:0] cp, logic [31:0] dp);
    logic w, i, b;
    @(negedge clk);
    intr_mode = im; branch_mode = bm; wait_mode = wm; dev_status = st;
    intr_select = is; branch_select = bs; wait_select = ws;
    cur_ptr = cp; dep_ptr = dp; eval_strobe = 1'b1;
    w = acts(wm, cond_true(ws, st));
    i = acts(im, cond_true(is, st));
    b = acts(bm, cond_true(bs, st));
    @(negedge clk);
    eval_strobe = 1'b0;
    check("R4", "result_valid", 32'(result_valid), 32'd1);
    if (w) begin
      check("R5", "stall", 32'(stall), 32'd1);
      check("R5", "irq_req", 32'(irq_req), 32'd0);
      check("R5", "writeback", 32'(writeback), 32'd0);
      check("R5", "branch_taken", 32'(branch_taken), 32'd0);
    end else begin
      exp_ptr = b ? dp : cp + 32'd16;
      exp_bt  = b;
      check("R5", "stall", 32'(stall), 32'd0);
      check("R6", "writeback", 32'(writeback), 32'd1);
      check("R6", "irq_req", 32'(irq_req), 32'(i));
      check(b ? "R7" : "R8", "branch_taken", 32'(branch_taken), 32'(b));
    end
    check(b && !w ? "R7" : "R8", "next_ptr", next_ptr, exp_ptr);
    check(b && !w ? "R7" : "R8", "bt_flag", 32'(bt_flag), 32'(exp_bt));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "result_valid", 32'(result_valid), 32'd0);
    check("R1", "stall", 32'(stall), 32'd0);
    check("R1", "irq_req", 32'(irq_req), 32'd0);
    check("R1", "writeback", 32'(writeback), 32'd0);
    check("R1", "next_ptr", next_ptr, 32'd0);
    check("R1", "bt_flag", 32'(bt_flag), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R4", "idle result_valid", 32'(result_valid), 32'd0);

    // R3 each encoding on the interrupt field with a true condition
    evaluate(2'b00, 2'b00, 2'b00, 4'h5, 32'h000F_0005, 0, 0, 32'h100, 32'h900);
    evaluate(2'b01, 2'b00, 2'b00, 4'h5, 32'h000F_0005, 0, 0, 32'h110, 32'h900);
    evaluate(2'b10, 2'b00, 2'b00, 4'h5, 32'h000F_0005, 0, 0, 32'h120, 32'h900);
    evaluate(2'b11, 2'b00, 2'b00, 4'h5, 32'h000F_0005, 0, 0, 32'h130, 32'h900);
    // R2 mask zero: always true; noise in unused bits
    evaluate(2'b01, 2'b01, 2'b00, 4'hA, 32'hFFF0_FFF3, 32'h5550_AAA6, 0, 32'h200, 32'h800);
    // R2 partial mask: only bit 1 compared
    evaluate(2'b01, 2'b10, 2'b00, 4'hD, 32'h0002_0000, 32'h0002_000F, 0, 32'h300, 32'h700);
    // R7 taken then R5 stall with interrupt forced always
    evaluate(2'b00, 2'b11, 2'b00, 4'h0, 0, 0, 0, 32'h400, 32'hABC0);
    evaluate(2'b11, 2'b11, 2'b11, 4'h0, 0, 0, 0, 32'h5550, 32'h6660);
    // R5 wait if-false stall
    evaluate(2'b11, 2'b00, 2'b10, 4'h1, 0, 0, 32'h000F_0002, 32'h7770, 32'h1110);
    // R8 wrap at top of address space
    evaluate(2'b00, 2'b00, 2'b00, 4'h0, 0, 0, 0, 32'hFFFF_FFF0, 32'h0);

    for (int n = 0; n < 400; n++) begin
      evaluate(2'($urandom), 2'($urandom), 2'($urandom), 4'($urandom),
               $urandom, $urandom, $urandom,
               {$urandom} & 32'hFFFF_FFF0, {$urandom} & 32'hFFFF_FFF0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule